// File: doc/BRIEF.md
# Nine-Bit Serial Transmitter

This block turns one byte plus an extra ninth bit into an asynchronous serial frame on a single output line. A frame holds one low start bit, the eight data bits with the least significant bit first, the ninth bit, and one high stop bit. The line rests high between frames. Software can use the ninth bit as a parity bit, or as a marker that tells address bytes apart from data bytes on a shared multi-drop link.

A frame starts when the byte-write strobe pulses while the transmitter is idle. The byte and the ninth-bit control value are captured in that same cycle. An external divider supplies a tick enable. Each bit lasts `BIT_TICKS` ticks that arrive after the frame was loaded.

A sticky done flag rises when the stop bit begins, not when it ends, so software can prepare the next byte during the stop bit. The flag stays set until software clears it. The flag also feeds a shared interrupt request, together with a receive-complete flag that comes from outside the block.

Top module: `ninebit_tx`

## Requirements
- R1: After synchronous reset, `tx_line_o` is 1 and `tx_busy_o`, `tx_done_o` and `irq_o` are 0.
- R2: A write (`byte_wr_i` = 1) while `tx_busy_o` = 0 is taken at that clock edge. From the next cycle `tx_busy_o` is 1 and `tx_line_o` is 0 (start bit).
- R3: Frame position k (0 = start, 1..8 = data bits 0..7, 9 = ninth bit, 10 = stop) is on `tx_line_o` while the number of ticks counted since the load lies in [k·BIT_TICKS, (k+1)·BIT_TICKS). Data bit 0 is sent first.
- R4: The ninth bit sent is the value of `ninth_bit_i` in the write cycle. Later changes of `ninth_bit_i` have no effect on the frame.
- R5: The stop bit is 1. `tx_busy_o` falls, and the line stays 1, once 11·BIT_TICKS ticks have been counted.
- R6: `tx_done_o` becomes 1 in the same cycle that the line moves to the stop bit, which is after 10·BIT_TICKS ticks.
- R7: `tx_done_o` stays 1 until `done_clr_i` is 1 at a clock edge. Clearing it during the stop bit does not shorten the frame. If the set and the clear fall on the same edge, the set wins.
- R8: A write while `tx_busy_o` = 1 is ignored. The current frame is unchanged and no frame follows it.
- R9: The data byte is the value of `byte_i` in the write cycle. Later changes of `byte_i` have no effect on the frame.
- R10: `irq_o` is a register equal to (`tx_done_o` | `rx_flag_i`) & `irq_en_i`. Its done term tracks `tx_done_o` in the same cycle. The `rx_flag_i` and `irq_en_i` terms take effect one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick_i | input | 1 | One-cycle tick from the external rate divider |
| byte_wr_i | input | 1 | Write strobe for the transmit byte |
| byte_i | input | DATA_BITS | Byte to send |
| ninth_bit_i | input | 1 | Ninth-bit control value |
| done_clr_i | input | 1 | Clears the done flag |
| rx_flag_i | input | 1 | Receive-complete flag from the companion receiver |
| irq_en_i | input | 1 | Interrupt enable |
| tx_line_o | output | 1 | Serial output, high when idle |
| tx_busy_o | output | 1 | High from the load until the stop bit ends |
| tx_done_o | output | 1 | Sticky flag, set at the start of the stop bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The frames use bytes with alternating, clustered and edge-only set bits, with both values of the ninth bit. These patterns separate an LSB-first order from an MSB-first order and show a ninth bit that is dropped or stuck. The tick spacing is varied: a tick every cycle, every second cycle and every third cycle. This shows whether bit length follows counted ticks rather than clock cycles. During each frame the byte and ninth-bit inputs are flipped, and one frame carries a write while busy, to reveal capture after the write cycle and restarts. The done clear is placed both in the middle of the stop bit and on the very edge that sets the flag, to tell the set-wins order apart from clear-wins.

// File: rtl/ninebit_tx_pkg.sv
package ninebit_tx_pkg;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_mode_e;

  // start + data + ninth + stop
  function automatic int unsigned frame_bits(input int unsigned data_bits);
    return data_bits + 3;
  endfunction

endpackage

// File: rtl/ninebit_tx_pacer.sv
module ninebit_tx_pacer #(
  parameter int unsigned BIT_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  input  logic tick,
  output logic bit_end
);

  localparam int unsigned CNT_W = (BIT_TICKS > 1) ? $clog2(BIT_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign bit_end = run & tick & (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (run && tick) begin
      cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // R3: the tick count inside one bit never passes the bit length
  assert_tick_count_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LAST);

  // R3: ticks are counted only while a frame runs
  assert_count_frozen_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/ninebit_tx_serializer.sv
module ninebit_tx_serializer
  import ninebit_tx_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] data,
  input  logic                 ninth,
  input  logic                 bit_end,
  output logic                 accept,
  output logic                 enter_stop,
  output logic                 busy,
  output logic                 line
);

  localparam int unsigned FRAME = frame_bits(DATA_BITS);
  localparam int unsigned IDX_W = $clog2(FRAME);
  localparam logic [IDX_W-1:0] IDX_STOP = IDX_W'(FRAME - 1);
  localparam logic [IDX_W-1:0] IDX_NINTH = IDX_W'(FRAME - 2);

  tx_mode_e         mode_q;
  logic [IDX_W-1:0] idx_q;
  logic [FRAME-1:0] shreg_q;

  assign accept     = load && (mode_q == TX_IDLE);
  assign enter_stop = bit_end && (mode_q == TX_SEND) && (idx_q == IDX_NINTH);
  assign busy       = (mode_q == TX_SEND);
  assign line       = shreg_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= TX_IDLE;
      idx_q   <= '0;
      shreg_q <= '1;
    end else if (accept) begin
      mode_q  <= TX_SEND;
      idx_q   <= '0;
      shreg_q <= {1'b1, ninth, data, 1'b0};
    end else if (bit_end && mode_q == TX_SEND) begin
      if (idx_q == IDX_STOP) begin
        mode_q  <= TX_IDLE;
        idx_q   <= '0;
        shreg_q <= '1;
      end else begin
        idx_q   <= idx_q + 1'b1;
        shreg_q <= {1'b1, shreg_q[FRAME-1:1]};
      end
    end
  end

  // R1: the line rests high whenever no frame is running
  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> line);

  // R2: a taken write yields busy and a low start bit next cycle
  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && !line));

  // R5: the stop position always drives a high level
  assert_stop_high_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && idx_q == IDX_STOP) |-> line);

  // R8: a write while busy leaves the frame untouched between bit edges
  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (load && busy && !bit_end) |=> ($stable(shreg_q) && $stable(idx_q)));

endmodule

// File: rtl/ninebit_tx_flags.sv
module ninebit_tx_flags (
  input  logic clk,
  input  logic rst,
  input  logic set_done,
  input  logic clr_done,
  input  logic rx_flag,
  input  logic irq_en,
  output logic done,
  output logic irq
);

  logic done_q;
  logic done_nxt;
  logic irq_q;

  always_comb begin
    done_nxt = done_q;
    if (set_done) begin
      done_nxt = 1'b1;
    end else if (clr_done) begin
      done_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_nxt;
      irq_q  <= (done_nxt | rx_flag) & irq_en;
    end
  end

  assign done = done_q;
  assign irq  = irq_q;

  // R7: without set or clear the flag keeps its value
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (!set_done && !clr_done) |=> $stable(done_q));

  // R7: a set on the same edge as a clear still leaves the flag high
  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (rst)
    set_done |=> done_q);

  // R10: an enabled receive flag raises the request on the next cycle
  assert_rx_irq_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_flag && irq_en) |=> irq_q);

  // R10: with interrupts disabled no request is raised
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq_q);

endmodule

// File: rtl/ninebit_tx.sv
module ninebit_tx #(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned BIT_TICKS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 baud_tick_i,
  input  logic                 byte_wr_i,
  input  logic [DATA_BITS-1:0] byte_i,
  input  logic                 ninth_bit_i,
  input  logic                 done_clr_i,
  input  logic                 rx_flag_i,
  input  logic                 irq_en_i,
  output logic                 tx_line_o,
  output logic                 tx_busy_o,
  output logic                 tx_done_o,
  output logic                 irq_o
);

  logic accept;
  logic enter_stop;
  logic bit_end;
  logic busy;

  ninebit_tx_pacer #(
    .BIT_TICKS(BIT_TICKS)
  ) pacer_i (
    .clk     (clk),
    .rst     (rst),
    .restart (accept),
    .run     (busy),
    .tick    (baud_tick_i),
    .bit_end (bit_end)
  );

  ninebit_tx_serializer #(
    .DATA_BITS(DATA_BITS)
  ) ser_i (
    .clk        (clk),
    .rst        (rst),
    .load       (byte_wr_i),
    .data       (byte_i),
    .ninth      (ninth_bit_i),
    .bit_end    (bit_end),
    .accept     (accept),
    .enter_stop (enter_stop),
    .busy       (busy),
    .line       (tx_line_o)
  );

  ninebit_tx_flags flags_i (
    .clk      (clk),
    .rst      (rst),
    .set_done (enter_stop),
    .clr_done (done_clr_i),
    .rx_flag  (rx_flag_i),
    .irq_en   (irq_en_i),
    .done     (tx_done_o),
    .irq      (irq_o)
  );

  assign tx_busy_o = busy;

  // R6: the done flag rises only while a frame is driving its stop bit
  assert_done_at_stop_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done_o) |-> (tx_busy_o && tx_line_o));

  // R5: the busy indication ends on a counted bit edge only
  assert_busy_end_on_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_busy_o && !bit_end) |=> tx_busy_o);

endmodule

// File: tb/ninebit_tx_tb_top.sv
module ninebit_tx_tb_top;

  localparam int BT = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] din = 8'h00;
  logic       nin = 1'b0;
  logic       clr = 1'b0;
  logic       rxf = 1'b0;
  logic       en = 1'b0;
  logic       line_o;
  logic       busy_o;
  logic       done_o;
  logic       irq_w;

  int checks = 0;
  int fails = 0;
  int tdiv = 3;
  int div = 0;
  logic exp_done = 1'b0;
  logic last_clr = 1'b0;

  always #4 clk = ~clk;

  ninebit_tx #(.DATA_BITS(8), .BIT_TICKS(BT)) dut_i (
    .clk(clk), .rst(rst), .baud_tick_i(tick), .byte_wr_i(wr), .byte_i(din),
    .ninth_bit_i(nin), .done_clr_i(clr), .rx_flag_i(rxf), .irq_en_i(en),
    .tx_line_o(line_o), .tx_busy_o(busy_o), .tx_done_o(done_o), .irq_o(irq_w)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic logic next_tick();
    logic t;
    t = (div == 0);
    div = (div + 1) % tdiv;
    return t;
  endfunction

  task automatic do_reset();
    rst = 1'b1; wr = 1'b0; clr = 1'b0; rxf = 1'b0; en = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    exp_done = 1'b0; last_clr = 1'b0;
    chk("R1", "reset line", line_o, 1'b1);
    chk("R1", "reset busy", busy_o, 1'b0);
    chk("R1", "reset done", done_o, 1'b0);
    chk("R1", "reset irq", irq_w, 1'b0);
  endtask

  // clr_mode: 0 none, 1 clear inside stop bit, 2 clear on the setting edge
  task automatic run_frame(input logic [7:0] d, input logic n9, input int clr_mode,
                           input int busy_wr_at);
    logic [10:0] frame;
    logic last_tick;
    logic cleared;
    int cnt;
    int idx;
    logic set_now;
    logic exp_line;
    frame = {1'b1, n9, d, 1'b0};
    cnt = 0; cleared = 1'b0;
    @(negedge clk);
    wr = 1'b1; din = d; nin = n9; clr = 1'b0;
    last_clr = 1'b0;
    last_tick = next_tick(); tick = last_tick;
    for (int s = 0; s < 4000; s++) begin
      @(negedge clk);
      set_now = 1'b0;
      if (s > 0 && last_tick) begin
        cnt++;
        if (cnt == 10 * BT) set_now = 1'b1;
      end
      if (set_now) exp_done = 1'b1;
      else if (last_clr) exp_done = 1'b0;
      idx = cnt / BT;
      exp_line = (idx < 11) ? frame[idx] : 1'b1;
      if (idx == 0) chk("R2", "start bit", line_o, exp_line);
      else if (idx <= 8) chk("R3,R9", "data bit", line_o, exp_line);
      else if (idx == 9) chk("R4", "ninth bit", line_o, exp_line);
      else chk("R5", "stop/idle level", line_o, exp_line);
      chk("R5", "busy", busy_o, idx < 11);
      chk(clr_mode != 0 ? "R7" : "R6", "done flag", done_o, exp_done);
      chk("R10", "irq", irq_w, (exp_done | rxf) & en);
      if (idx >= 11) break;
      wr = 1'b0;
      if (s == busy_wr_at) wr = 1'b1;
      din = ~d; nin = ~n9;
      last_tick = next_tick(); tick = last_tick;
      clr = 1'b0;
      if (clr_mode == 1 && idx == 10 && exp_done && !cleared) begin
        clr = 1'b1; cleared = 1'b1;
      end
      if (clr_mode == 2 && last_tick && (cnt + 1 == 10 * BT)) clr = 1'b1;
      last_clr = clr;
    end
    wr = 1'b0; clr = 1'b0; last_clr = 1'b0;
    // after the frame: no second frame from an ignored write
    for (int s = 0; s < 3 * BT * tdiv; s++) begin
      @(negedge clk);
      tick = next_tick();
      chk("R8", "stays idle after frame", busy_o, 1'b0);
      chk("R8", "line idle after frame", line_o, 1'b1);
    end
  endtask

  task automatic irq_cases();
    // done currently set; mask it
    @(negedge clk); en = 1'b0; rxf = 1'b0; tick = 1'b0;
    @(negedge clk);
    chk("R10", "masked done", irq_w, 1'b0);
    en = 1'b1;
    @(negedge clk);
    chk("R10", "enabled done", irq_w, exp_done);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; exp_done = 1'b0;
    chk("R7", "done cleared", done_o, 1'b0);
    chk("R10", "irq follows clear", irq_w, 1'b0);
    rxf = 1'b1;
    @(negedge clk);
    chk("R10", "rx flag request", irq_w, 1'b1);
    en = 1'b0;
    @(negedge clk);
    chk("R10", "rx masked", irq_w, 1'b0);
    rxf = 1'b0;
    @(negedge clk);
    chk("R10", "all quiet", irq_w, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    tdiv = 3; div = 0;
    run_frame(8'hA5, 1'b1, 0, -1);
    tdiv = 1; div = 0;
    run_frame(8'h3C, 1'b0, 0, 5);
    tdiv = 2; div = 0;
    run_frame(8'h81, 1'b1, 1, 9);
    tdiv = 1; div = 0;
    run_frame(8'h7E, 1'b0, 2, -1);
    irq_cases();
    en = 1'b1;
    tdiv = 3; div = 0;
    run_frame(8'h01, 1'b1, 0, 20);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule